// File: doc/BRIEF.md
# Transmit Frame Word-to-Byte Serializer

This block sits between a user application that delivers transmit frames as 32-bit words and a MAC transmit path that consumes one byte per cycle. Each accepted word is split into bytes, most significant byte first. The final word of a frame carries a two-bit empty count, and the block drops the unused low-order bytes of that word. Per-frame side information goes out with the byte stream. This includes a start marker, an end marker, an error bit and a request for the downstream MAC to insert a CRC.

The input side follows a valid/ready handshake. Ready drops while the bytes of a word are still being shifted out. It comes back in the cycle that shows the last byte of that word, so full words stream with no idle output cycles. The block also guards frame integrity. A frame is closed with an error terminator byte in two cases: when the application stops presenting data in the middle of a frame, or when it starts a new frame before ending the current one. Stray words that arrive outside any frame are dropped.

Top module: `tx_word_serializer`

## Requirements
- R1: The bytes of an accepted word appear on `out_byte` in the order bits 31:24, 23:16, 15:8, 7:0, one byte per cycle. The first byte appears in the cycle after the accepting clock edge.
- R2: On a word with `in_eop` high, `in_empty` gives the number of trailing invalid bytes: 0 means 4 bytes, 1 means 3, 2 means 2 and 3 means 1. The last valid byte is the only one emitted with `out_last` high.
- R3: `out_first` is high exactly on the first byte of a word accepted with `in_sop` high. `in_empty` has no effect on words without `in_eop`.
- R4: `in_err` sampled with the end-of-packet word sets `out_err` on that frame's last byte. `out_err` is never high without `out_last`.
- R5: `out_crc_ins` on a frame's last byte is the inverse of `in_crc_fwd` sampled with the end-of-packet word (0 requests insertion). It is low on every other byte.
- R6: A word is taken only on a clock edge where `in_valid` and `in_ready` are both high. After a 4-byte word is taken, `in_ready` stays low until the cycle showing its last byte. Back-to-back words therefore give an unbroken byte stream.
- R7: If `in_valid` is low in a cycle where a frame is open and `in_ready` is high, the block emits a terminator byte: value 0x00, with `out_last`=1, `out_err`=1, `out_crc_ins`=0 and `out_first`=0. This closes the frame.
- R8: A start-of-packet word that arrives while a frame is open first produces the terminator byte of R7. Its own bytes follow in the next cycles.
- R9: A synchronous high `rst` returns the block to idle. No frame is open, `out_valid`, `out_first`, `out_last`, `out_err` and `out_crc_ins` are low, and `in_ready` is high.
- R10: Words accepted while no frame is open and without `in_sop` produce no output bytes. This includes words that arrive after a truncation and before the next start of packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can take a word this cycle |
| in_data | input | 32 | Input word, first byte in bits 31:24 |
| in_empty | input | 2 | Invalid trailing bytes on the end-of-packet word |
| in_sop | input | 1 | Word starts a frame |
| in_eop | input | 1 | Word ends a frame |
| in_err | input | 1 | Frame error, sampled with end of packet |
| in_crc_fwd | input | 1 | 1: application supplies CRC, sampled with end of packet |
| out_byte | output | 8 | Output byte |
| out_valid | output | 1 | Output byte valid |
| out_first | output | 1 | First byte of a frame |
| out_last | output | 1 | Last byte of a frame |
| out_err | output | 1 | Frame error, on the last byte |
| out_crc_ins | output | 1 | Request CRC insertion, on the last byte |

## Verification
The bound checker enforces several rules on every cycle. The error and CRC-request bits only ride on a last byte. Markers never appear without a valid byte. A taken start-of-packet word always yields an output byte in the next cycle. A taken multi-byte start word always drops ready, and the outputs are quiet right after reset. Byte order, the empty-count decoding, the sampling of the error and CRC flags, and the placement of terminator bytes can only be shown by the scoreboard scenarios. These scenarios cover back-to-back words, single-word frames with every empty value, a gap in the middle of a frame followed by stray words, a start of packet inside an open frame, and a reset in the middle of a frame.

// File: rtl/tx_ser_pkg.sv
package tx_ser_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic sop;
    logic eop;
    logic err;
    logic crc_fwd;
  } tx_meta_t;
endpackage

// File: rtl/tx_ser_frame.sv
module tx_ser_frame (
  input  logic clk,
  input  logic rst,
  input  logic valid_i,
  input  logic sop_i,
  input  logic eop_i,
  input  logic ready_i,
  output logic load_o,
  output logic term_o
);
  logic open_q;
  logic accept;
  logic gap_close;
  logic sop_close;

  assign accept    = valid_i && ready_i;
  assign gap_close = open_q && ready_i && !valid_i;
  assign sop_close = open_q && accept && sop_i;
  assign term_o    = gap_close || sop_close;
  assign load_o    = accept && (open_q || sop_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
    end else if (accept && sop_i) begin
      open_q <= !eop_i;
    end else if (accept && open_q && eop_i) begin
      open_q <= 1'b0;
    end else if (gap_close) begin
      open_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tx_ser_unpack.sv
module tx_ser_unpack
  import tx_ser_pkg::*;
#(
  parameter  int LANES  = 4,
  localparam int DATA_W = LANES * BYTE_W,
  localparam int MOD_W  = $clog2(LANES),
  localparam int CNT_W  = $clog2(LANES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              term_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [MOD_W-1:0]  empty_i,
  input  tx_meta_t          meta_i,
  output logic              ready_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              valid_o,
  output logic              first_o,
  output logic              last_o,
  output logic              err_o,
  output logic              crc_ins_o
);
  logic [DATA_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              pfirst_q, peop_q, perr_q, pcrc_q;
  logic [CNT_W-1:0]  word_bytes;
  logic              load_single;
  logic              pend_last;

  always_comb begin
    word_bytes = meta_i.eop ? (CNT_W'(LANES) - CNT_W'(empty_i)) : CNT_W'(LANES);
  end

  assign load_single = meta_i.eop && (word_bytes == CNT_W'(1));
  assign pend_last   = peop_q && (cnt_q == CNT_W'(1));
  assign ready_o     = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q      <= '0;
      cnt_q     <= '0;
      pfirst_q  <= 1'b0;
      peop_q    <= 1'b0;
      perr_q    <= 1'b0;
      pcrc_q    <= 1'b0;
      byte_o    <= '0;
      valid_o   <= 1'b0;
      first_o   <= 1'b0;
      last_o    <= 1'b0;
      err_o     <= 1'b0;
      crc_ins_o <= 1'b0;
    end else if (term_i) begin
      byte_o    <= '0;
      valid_o   <= 1'b1;
      first_o   <= 1'b0;
      last_o    <= 1'b1;
      err_o     <= 1'b1;
      crc_ins_o <= 1'b0;
      if (load_i) begin
        sh_q     <= data_i;
        cnt_q    <= word_bytes;
        pfirst_q <= meta_i.sop;
        peop_q   <= meta_i.eop;
        perr_q   <= meta_i.err;
        pcrc_q   <= !meta_i.crc_fwd;
      end
    end else if (load_i) begin
      byte_o    <= data_i[DATA_W-1 -: BYTE_W];
      valid_o   <= 1'b1;
      first_o   <= meta_i.sop;
      last_o    <= load_single;
      err_o     <= load_single && meta_i.err;
      crc_ins_o <= load_single && !meta_i.crc_fwd;
      sh_q      <= data_i << BYTE_W;
      cnt_q     <= word_bytes - CNT_W'(1);
      pfirst_q  <= 1'b0;
      peop_q    <= meta_i.eop;
      perr_q    <= meta_i.err;
      pcrc_q    <= !meta_i.crc_fwd;
    end else if (cnt_q != '0) begin
      byte_o    <= sh_q[DATA_W-1 -: BYTE_W];
      valid_o   <= 1'b1;
      first_o   <= pfirst_q;
      last_o    <= pend_last;
      err_o     <= pend_last && perr_q;
      crc_ins_o <= pend_last && pcrc_q;
      sh_q      <= sh_q << BYTE_W;
      cnt_q     <= cnt_q - CNT_W'(1);
      pfirst_q  <= 1'b0;
    end else begin
      byte_o    <= '0;
      valid_o   <= 1'b0;
      first_o   <= 1'b0;
      last_o    <= 1'b0;
      err_o     <= 1'b0;
      crc_ins_o <= 1'b0;
    end
  end
endmodule

// File: rtl/tx_word_serializer.sv
module tx_word_serializer
  import tx_ser_pkg::*;
#(
  parameter  int LANES  = 4,
  localparam int DATA_W = LANES * BYTE_W,
  localparam int MOD_W  = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [MOD_W-1:0]  in_empty,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic              in_err,
  input  logic              in_crc_fwd,
  output logic [BYTE_W-1:0] out_byte,
  output logic              out_valid,
  output logic              out_first,
  output logic              out_last,
  output logic              out_err,
  output logic              out_crc_ins
);
  logic     load;
  logic     term;
  tx_meta_t meta;

  assign meta = '{sop: in_sop, eop: in_eop, err: in_err, crc_fwd: in_crc_fwd};

  tx_ser_frame u_frame (
    .clk     (clk),
    .rst     (rst),
    .valid_i (in_valid),
    .sop_i   (in_sop),
    .eop_i   (in_eop),
    .ready_i (in_ready),
    .load_o  (load),
    .term_o  (term)
  );

  tx_ser_unpack #(.LANES(LANES)) u_unpack (
    .clk       (clk),
    .rst       (rst),
    .term_i    (term),
    .load_i    (load),
    .data_i    (in_data),
    .empty_i   (in_empty),
    .meta_i    (meta),
    .ready_o   (in_ready),
    .byte_o    (out_byte),
    .valid_o   (out_valid),
    .first_o   (out_first),
    .last_o    (out_last),
    .err_o     (out_err),
    .crc_ins_o (out_crc_ins)
  );
endmodule

// File: rtl/tx_ser_checker.sv
module tx_ser_checker (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_ready,
  input logic in_sop,
  input logic in_eop,
  input logic out_valid,
  input logic out_first,
  input logic out_last,
  input logic out_err,
  input logic out_crc_ins
);
  AST_ERR_ONLY_ON_LAST: assert property (@(posedge clk) disable iff (rst)
    out_err |-> (out_last && out_valid)); // R4
  AST_CRC_REQ_ON_LAST: assert property (@(posedge clk) disable iff (rst)
    out_crc_ins |-> (out_last && out_valid)); // R5
  AST_FIRST_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    out_first |-> out_valid); // R3
  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid); // R2
  AST_READY_DROPS_ON_WORD: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_sop && !in_eop) |=> !in_ready); // R6
  AST_SOP_GIVES_BYTE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_sop) |=> out_valid); // R1
  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && in_ready)); // R9
endmodule

bind tx_word_serializer tx_ser_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_sop      (in_sop),
  .in_eop      (in_eop),
  .out_valid   (out_valid),
  .out_first   (out_first),
  .out_last    (out_last),
  .out_err     (out_err),
  .out_crc_ins (out_crc_ins)
);

// File: tb/tb_tx_word_serializer.sv
`timescale 1ns/1ps
module tb_tx_word_serializer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic [1:0]  in_empty = '0;
  logic        in_sop = 1'b0, in_eop = 1'b0, in_err = 1'b0, in_crc_fwd = 1'b0;
  logic [7:0]  out_byte;
  logic        out_valid, out_first, out_last, out_err, out_crc_ins;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int t_first = 0;
  int t_last  = 0;
  bit open_m = 1'b0;
  bit done   = 1'b0;

  logic [11:0] expq[$];
  string       tagq[$];

  always #2.5 clk = ~clk;

  tx_word_serializer dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_empty(in_empty), .in_sop(in_sop), .in_eop(in_eop),
    .in_err(in_err), .in_crc_fwd(in_crc_fwd), .out_byte(out_byte),
    .out_valid(out_valid), .out_first(out_first), .out_last(out_last),
    .out_err(out_err), .out_crc_ins(out_crc_ins)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b, input bit f, input bit l, input bit e,
                      input bit c, input string tag);
    expq.push_back({b, f, l, e, c});
    tagq.push_back(tag);
  endtask

  // drive one word; starts and ends at a falling edge, leaves valid high
  task automatic put(input logic [31:0] d, input logic [1:0] e, input bit s,
                     input bit eo, input bit er, input bit cf, input string tag);
    if (open_m || s) begin
      int n;
      if (open_m && s) push(8'h00, 0, 1, 1, 0, "R8");
      n = eo ? 4 - int'(e) : 4;
      for (int i = 0; i < n; i++)
        push(d[31-8*i -: 8], s && i == 0, eo && i == n-1, eo && i == n-1 && er,
             eo && i == n-1 && !cf, tag);
      open_m = !eo;
    end
    in_valid = 1'b1; in_data = d; in_empty = e; in_sop = s; in_eop = eo;
    in_err = er; in_crc_fwd = cf;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    if (open_m && n >= 4) begin
      push(8'h00, 0, 1, 1, 0, "R7");
      open_m = 1'b0;
    end
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    cyc++;
    if (!rst && out_valid) begin
      logic [11:0] act;
      act = {out_byte, out_first, out_last, out_err, out_crc_ins};
      if (out_first) t_first = cyc;
      if (out_last)  t_last  = cyc;
      if (expq.size() == 0) begin
        chk(1'b0, "R10 unexpected byte", int'(act), 0);
      end else begin
        logic [11:0] exp;
        string tg;
        exp = expq.pop_front();
        tg  = tagq.pop_front();
        chk(act == exp, tg, int'(act), int'(exp));
      end
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 0, "R9 reset valid", out_valid, 0);
    chk(in_ready == 1, "R9 reset ready", in_ready, 1);
    chk(out_last == 0 && out_err == 0, "R9 reset flags", {out_last, out_err}, 0);

    // multi-word frame, back to back
    put(32'h11223344, 2'd0, 1, 0, 0, 0, "R1");
    chk(in_ready == 0, "R6 ready low during word", in_ready, 0);
    put(32'h55667788, 2'd3, 0, 0, 0, 0, "R3");
    put(32'h99AABBCC, 2'd0, 0, 1, 0, 0, "R5");
    idle(6);
    chk(t_last - t_first == 11, "R6 unbroken stream", t_last - t_first, 11);

    // single-word frames, every empty value
    for (int e = 0; e < 4; e++)
      put(32'hA0B0C0D0 + 32'(e), 2'(e), 1, 1, 0, e[0], "R2");
    idle(6);

    // error with end of packet, CRC supplied
    put(32'h01020304, 2'd0, 1, 0, 0, 0, "R4");
    put(32'h05060708, 2'd2, 0, 1, 1, 1, "R4");
    idle(6);

    // gap mid-frame, then stray words, then a new frame
    put(32'hDEADBEEF, 2'd0, 1, 0, 0, 0, "R7");
    put(32'hCAFEF00D, 2'd0, 0, 0, 0, 0, "R7");
    idle(6);
    put(32'h0BADC0DE, 2'd0, 0, 0, 0, 0, "R10");
    put(32'h0F0F0F0F, 2'd1, 0, 1, 1, 0, "R10");
    idle(6);
    put(32'h12345678, 2'd0, 1, 1, 0, 0, "R7");
    idle(6);

    // start of packet inside open frame
    put(32'h21222324, 2'd0, 1, 0, 0, 0, "R8");
    put(32'h31323334, 2'd0, 1, 0, 0, 0, "R8");
    put(32'h41424344, 2'd1, 0, 1, 0, 0, "R8");
    idle(6);

    // reset in the middle of a frame
    put(32'h51525354, 2'd0, 1, 0, 0, 0, "R9");
    rst = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    expq.delete();
    tagq.delete();
    open_m = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 0, "R9 mid-frame reset valid", out_valid, 0);
    chk(in_ready == 1, "R9 mid-frame reset ready", in_ready, 1);
    put(32'h61626364, 2'd0, 1, 1, 0, 1, "R9");
    idle(6);

    chk(expq.size() == 0, "R10 all bytes seen", expq.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule